// File: doc/BRIEF.md
# Threshold-Gate Magnitude Comparator

This block compares two unsigned operands of equal width, `opa` and `opb`. It reports all five ordering relations at once: greater, greater-or-equal, less, less-or-equal and equal. It has no clock. Every flag follows the operands combinationally, so a datapath can sample any subset of them in the same cycle in which it presents the operands.

Each ordering flag is a single threshold neuron. The neuron has one input for each of the 16 operand bits, and each input carries a positional weight. The bits of one operand get weights +2^k and the bits of the other operand get weights −2^k. The neuron's sum is therefore the signed difference of the two operands. A bias of −1 makes a flag strict and a bias of 0 makes it non-strict. The neuron fires when sum plus bias is zero or more. Equality is computed in a second layer: a two-input neuron with unit weights and bias −2 takes the two non-strict flags and fires only when both are set.

The block is built from a small set of modules:
- A package that names the four ordering relations and maps each one to its bias and its sign orientation.
- A generate bank that instantiates one neuron per relation.
- A second-layer neuron for equality.

Because the block is purely combinational, it has no states and no transitions.

Top module: `mag_cmp_unit`

## Requirements
- R1: `gt_o` is 1 exactly when `opa` > `opb`, with both operands read as unsigned binary numbers.
- R2: `ge_o` is 1 exactly when `opa` >= `opb` (unsigned).
- R3: `lt_o` is 1 exactly when `opa` < `opb` (unsigned).
- R4: `le_o` is 1 exactly when `opa` <= `opb` (unsigned).
- R5: `eq_o` is 1 exactly when `opa` equals `opb`.
- R6: For every operand pair, exactly one of `gt_o`, `lt_o` and `eq_o` is 1.
- R7: `ge_o` is always the complement of `lt_o`, and `le_o` is always the complement of `gt_o`.
- R8: At the extremes of the range, where the weighted difference reaches +(2^W−1) or −(2^W−1), the flags are still correct: (max, 0) sets only `gt_o` and `ge_o`, (0, max) sets only `lt_o` and `le_o`, and (0, 0) and (max, max) set `ge_o`, `le_o` and `eq_o`.
- R9: All five flags reflect the current operands within the same cycle, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (8) | First unsigned operand |
| opb | input | W (8) | Second unsigned operand |
| gt_o | output | 1 | opa strictly greater than opb |
| ge_o | output | 1 | opa greater than or equal to opb |
| lt_o | output | 1 | opa strictly less than opb |
| le_o | output | 1 | opa less than or equal to opb |
| eq_o | output | 1 | opa equal to opb |

## Verification
The bench builds the unit with its default operand width of 8 bits. At that width the full cross product of 65,536 operand pairs can be swept. Every pair is compared against the language's own unsigned relational operators. The sweep therefore reaches the difference extremes of ±255, every zero-difference diagonal point, and every off-by-one boundary between strict and non-strict flags, with nothing sampled at random. The flags are read a fraction of a cycle after the operands change, without waiting for a clock edge, which exercises the purely combinational timing.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // The four first-layer ordering relations
    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_GE = 2'd1,
        REL_LT = 2'd2,
        REL_LE = 2'd3
    } rel_e;

    localparam int NUM_REL = 4;

    // Strict relations need a sum of at least 1, non-strict at least 0
    function automatic int rel_bias(input rel_e r);
        return (r == REL_GT || r == REL_LT) ? -1 : 0;
    endfunction

    // Less-type relations swap which operand carries the positive weights
    function automatic bit rel_flip(input rel_e r);
        return (r == REL_LT || r == REL_LE);
    endfunction

endpackage

// File: rtl/cmp_thresh_neuron.sv
module cmp_thresh_neuron #(
    parameter int W    = 8,
    parameter int BIAS = 0,
    parameter bit FLIP = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         fire
);
    localparam int N     = 2 * W;
    localparam int SUM_W = W + 2;

    logic [N-1:0]             x;
    logic signed [SUM_W-1:0]  acc;

    // Upper half holds operand a, lower half operand b
    assign x = {a, b};

    always_comb begin
        acc = SUM_W'(BIAS);
        for (int j = 0; j < N; j++) begin
            logic signed [SUM_W-1:0] mag;
            mag = SUM_W'(1) << (j % W);
            if (x[j]) begin
                if ((j >= W) != FLIP) acc = acc + mag;
                else                  acc = acc - mag;
            end
        end
        fire = ~acc[SUM_W-1];
    end

endmodule

// File: rtl/cmp_and_neuron.sv
module cmp_and_neuron (
    input  logic p,
    input  logic q,
    output logic fire
);
    localparam int SUM_W = 3;

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc  = -SUM_W'(2) + SUM_W'(p) + SUM_W'(q);
        fire = ~acc[SUM_W-1];
    end

endmodule

// File: rtl/cmp_order_bank.sv
module cmp_order_bank
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output logic [NUM_REL-1:0]   rel
);
    for (genvar r = 0; r < NUM_REL; r++) begin : g_rel
        localparam rel_e KIND = rel_e'(r);
        cmp_thresh_neuron #(
            .W    (W),
            .BIAS (rel_bias(KIND)),
            .FLIP (rel_flip(KIND))
        ) u_neuron (
            .a    (a),
            .b    (b),
            .fire (rel[r])
        );
    end

endmodule

// File: rtl/mag_cmp_unit.sv
module mag_cmp_unit
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         gt_o,
    output logic         ge_o,
    output logic         lt_o,
    output logic         le_o,
    output logic         eq_o
);
    logic [NUM_REL-1:0] rel;

    cmp_order_bank #(.W(W)) u_bank (
        .a   (opa),
        .b   (opb),
        .rel (rel)
    );

    assign gt_o = rel[REL_GT];
    assign ge_o = rel[REL_GE];
    assign lt_o = rel[REL_LT];
    assign le_o = rel[REL_LE];

    cmp_and_neuron u_eq (
        .p    (rel[REL_GE]),
        .q    (rel[REL_LE]),
        .fire (eq_o)
    );

    always_comb begin
        // R6
        one_rel_chk: assert ($onehot({gt_o, lt_o, eq_o}));
        // R7
        ge_not_lt_chk: assert (ge_o == !lt_o);
        // R7
        le_not_gt_chk: assert (le_o == !gt_o);
        // R1
        gt_order_chk: assert (!gt_o || (opa > opb));
        // R3
        lt_order_chk: assert (!lt_o || (opa < opb));
    end

endmodule

// File: tb/mag_cmp_unit_tb.sv
module mag_cmp_unit_tb;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb;
    logic         gt_o, ge_o, lt_o, le_o, eq_o;
    int           n_tests = 0;
    int           n_fail  = 0;

    always #5 clk = ~clk;

    mag_cmp_unit #(.W(W)) u_dut (
        .opa  (opa),
        .opb  (opb),
        .gt_o (gt_o),
        .ge_o (ge_o),
        .lt_o (lt_o),
        .le_o (le_o),
        .eq_o (eq_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d act=%b exp=%b", req, opa, opb, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(posedge clk);
        #1;
        opa = W'(a);
        opb = W'(b);
        #2;  // R9: no clock edge between drive and sample
        check("R1 gt", gt_o, a > b);
        check("R2 ge", ge_o, a >= b);
        check("R3 lt", lt_o, a < b);
        check("R4 le", le_o, a <= b);
        check("R5 eq", eq_o, a == b);
        check("R6 onehot", ((gt_o + lt_o + eq_o) == 1), 1'b1);
        check("R7 compl", (ge_o == !lt_o) && (le_o == !gt_o), 1'b1);
    endtask

    task automatic corner(input int a, input int b, input logic [4:0] exp);
        apply(a, b);
        check("R8 extreme", {gt_o, ge_o, lt_o, le_o, eq_o} == exp, 1'b1);
    endtask

    initial begin
        opa = '0;
        opb = '0;
        #2;
        check("R5 initial eq", eq_o, 1'b1);
        check("R1 initial gt", gt_o, 1'b0);
        // R8 corners, flags ordered gt,ge,lt,le,eq
        corner(MAX, 0,   5'b11000);
        corner(0,   MAX, 5'b00110);
        corner(0,   0,   5'b01011);
        corner(MAX, MAX, 5'b01011);
        corner(1,   0,   5'b11000);
        corner(0,   1,   5'b00110);
        for (int a = 0; a <= MAX; a++) begin
            for (int b = 0; b <= MAX; b++) begin
                apply(a, b);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule